// File: doc/BRIEF.md
# Audio Channel Activation Gate

This block stands between eight audio sample lanes, split into two groups of four, and the stage that builds audio packets. Each input strobe carries one packet slot holding one sample for every channel. A host writes an 8-bit activation mask and two 2-bit group identifiers through a plain address, data and write-enable port. For every slot the block decides which of the two groups go into a packet. Inside an emitted group, active channels pass their samples and inactive channels carry a null sample with every bit zero.

A group is dropped only when all four of its channels are inactive. When no channel is active, no slot is produced. Host writes land in a staging copy. They are moved into the working copy only on a slot marked as the start of a packet, so no packet mixes two configurations. When both groups are active and carry the same identifier, the block flags a configuration error and emits only the first group.

Top module: `audio_act_gate`

## Requirements
- R1: After reset the staged and working activation masks are 0xFF, identifier A is 0, identifier B is 1 and out_valid is 0. The first packet-start slot emits both groups with all samples passed.
- R2: Lane n of out_samples (bits n*SAMPLE_W and up, where n=0..7 is channel n+1) equals lane n of in_samples from the previous cycle's slot when mask bit n is set and its group is emitted.
- R3: A lane whose mask bit is clear is all zero in the output slot, and so is every lane of a group that is not emitted.
- R4: out_emit_a is 0 exactly when mask bits 3:0 (channels 1 to 4) are all clear.
- R5: out_emit_b is 0 when mask bits 7:4 (channels 5 to 8) are all clear.
- R6: When all eight mask bits are clear, out_valid stays 0 even though in_valid was 1.
- R7: A host write changes the working configuration only at the next slot with in_valid and in_sop both 1, and that slot already uses it. Slots without in_sop use the configuration committed earlier.
- R8: out_valid rises one cycle after an input slot and falls one cycle after in_valid falls. out_id_a and out_id_b carry the working identifiers of that slot.
- R9: If both groups have an active channel and the two identifiers are equal, out_cfg_err is 1, out_emit_b is 0 and the group B lanes are zero. Otherwise out_cfg_err is 0.
- R10: A write to address MASK_ADDR (0) loads wr_data[7:0] as the mask. A write to ID_ADDR (1) loads wr_data[1:0] as identifier A and wr_data[3:2] as identifier B. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host register address |
| wr_data | input | DATA_W | Host register write data |
| in_valid | input | 1 | Input slot strobe |
| in_sop | input | 1 | Slot is the first of a packet (commit point) |
| in_samples | input | 8*SAMPLE_W | Eight channel samples, channel 1 in the low lane |
| out_valid | output | 1 | Output slot strobe |
| out_emit_a | output | 1 | Group A is emitted in this slot |
| out_emit_b | output | 1 | Group B is emitted in this slot |
| out_id_a | output | 2 | Identifier of group A |
| out_id_b | output | 2 | Identifier of group B |
| out_cfg_err | output | 1 | Both groups active with equal identifiers |
| out_samples | output | 8*SAMPLE_W | Gated sample lanes |

## Verification
The embedded properties check on every cycle that the output strobe follows an input slot, that a valid slot always emits some group, that a suppressed group's lanes are zero, that a conflict never emits group B, that the working configuration moves only on a packet-start slot, and that writes to unused addresses leave the staging copy alone. The exact sample values and the reset configuration are shown only by the bench's scenarios. So are the exact flag values for each mask pattern and the order between a host write and the next commit, all compared against a model of the staged and working configuration.

// File: rtl/aag_pkg.sv
package aag_pkg;
   localparam int GRP_CH  = 4;
   localparam int NUM_GRP = 2;
   localparam int NUM_CH  = GRP_CH * NUM_GRP;
   localparam int ID_W    = 2;

   typedef struct packed {
      logic [NUM_CH-1:0] mask;
      logic [ID_W-1:0]   id_a;
      logic [ID_W-1:0]   id_b;
   } aag_cfg_t;
endpackage

// File: rtl/aag_regs.sv
module aag_regs
   import aag_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int MASK_ADDR = 0,
   parameter int ID_ADDR   = 1,
   parameter int RST_ID_A  = 0,
   parameter int RST_ID_B  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output aag_cfg_t          stage_cfg
);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
   localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_ADDR);

   generate
      if (DATA_W < NUM_CH || DATA_W < 2 * ID_W) begin : g_bad_dw
         $error("aag_regs: DATA_W too narrow");
      end
      if (MASK_ADDR == ID_ADDR) begin : g_bad_addr
         $error("aag_regs: register addresses collide");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_cfg.mask <= '1;
         stage_cfg.id_a <= ID_W'(RST_ID_A);
         stage_cfg.id_b <= ID_W'(RST_ID_B);
      end else if (wr_en) begin
         if (wr_addr == MASK_A) begin
            stage_cfg.mask <= wr_data[NUM_CH-1:0];
         end
         if (wr_addr == ID_A) begin
            stage_cfg.id_a <= wr_data[ID_W-1:0];
            stage_cfg.id_b <= wr_data[2*ID_W-1:ID_W];
         end
      end
   end

   // R10
   unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != MASK_A && wr_addr != ID_A) |=> $stable(stage_cfg));
endmodule

// File: rtl/aag_commit.sv
module aag_commit
   import aag_pkg::*;
#(
   parameter int RST_ID_A = 0,
   parameter int RST_ID_B = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     in_valid,
   input  logic     in_sop,
   input  aag_cfg_t stage_cfg,
   output aag_cfg_t eff_cfg
);
   aag_cfg_t act_cfg;
   logic     commit;

   assign commit  = in_valid && in_sop;
   assign eff_cfg = commit ? stage_cfg : act_cfg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_cfg.mask <= '1;
         act_cfg.id_a <= ID_W'(RST_ID_A);
         act_cfg.id_b <= ID_W'(RST_ID_B);
      end else if (commit) begin
         act_cfg <= stage_cfg;
      end
   end

   // R7
   commit_only_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_sop) |=> $stable(act_cfg));
endmodule

// File: rtl/aag_lane_gate.sv
module aag_lane_gate
   import aag_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic [GRP_CH*SAMPLE_W-1:0] lanes_in,
   input  logic [GRP_CH-1:0]          ch_on,
   input  logic                       grp_emit,
   output logic [GRP_CH*SAMPLE_W-1:0] lanes_out
);
   generate
      if (SAMPLE_W < 1) begin : g_bad_sw
         $error("aag_lane_gate: SAMPLE_W must be positive");
      end
      for (genvar c = 0; c < GRP_CH; c++) begin : g_lane
         assign lanes_out[c*SAMPLE_W +: SAMPLE_W] =
            (ch_on[c] && grp_emit) ? lanes_in[c*SAMPLE_W +: SAMPLE_W] : '0;
      end
   endgenerate
endmodule

// File: rtl/audio_act_gate.sv
module audio_act_gate
   import aag_pkg::*;
#(
   parameter int SAMPLE_W  = 24,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int MASK_ADDR = 0,
   parameter int ID_ADDR   = 1,
   parameter int RST_ID_A  = 0,
   parameter int RST_ID_B  = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       in_valid,
   input  logic                       in_sop,
   input  logic [NUM_CH*SAMPLE_W-1:0] in_samples,
   output logic                       out_valid,
   output logic                       out_emit_a,
   output logic                       out_emit_b,
   output logic [ID_W-1:0]            out_id_a,
   output logic [ID_W-1:0]            out_id_b,
   output logic                       out_cfg_err,
   output logic [NUM_CH*SAMPLE_W-1:0] out_samples
);
   localparam int GRP_BITS = GRP_CH * SAMPLE_W;

   aag_cfg_t                   stage_cfg;
   aag_cfg_t                   eff_cfg;
   logic [NUM_GRP-1:0]         grp_any;
   logic [NUM_GRP-1:0]         grp_emit;
   logic                       conflict;
   logic [NUM_CH*SAMPLE_W-1:0] gated;

   aag_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_ADDR(MASK_ADDR),
      .ID_ADDR(ID_ADDR), .RST_ID_A(RST_ID_A), .RST_ID_B(RST_ID_B)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .stage_cfg(stage_cfg)
   );

   aag_commit #(.RST_ID_A(RST_ID_A), .RST_ID_B(RST_ID_B)) commit_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .stage_cfg(stage_cfg), .eff_cfg(eff_cfg)
   );

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         assign grp_any[g] = |eff_cfg.mask[g*GRP_CH +: GRP_CH];
      end
   endgenerate

   assign conflict    = grp_any[0] && grp_any[1] && (eff_cfg.id_a == eff_cfg.id_b);
   assign grp_emit[0] = grp_any[0];
   assign grp_emit[1] = grp_any[1] && !conflict;

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_gate
         aag_lane_gate #(.SAMPLE_W(SAMPLE_W)) gate_i (
            .lanes_in (in_samples[g*GRP_BITS +: GRP_BITS]),
            .ch_on    (eff_cfg.mask[g*GRP_CH +: GRP_CH]),
            .grp_emit (grp_emit[g]),
            .lanes_out(gated[g*GRP_BITS +: GRP_BITS])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_emit_a  <= 1'b0;
         out_emit_b  <= 1'b0;
         out_id_a    <= ID_W'(RST_ID_A);
         out_id_b    <= ID_W'(RST_ID_B);
         out_cfg_err <= 1'b0;
         out_samples <= '0;
      end else begin
         out_valid <= in_valid && (|grp_emit);
         if (in_valid) begin
            out_emit_a  <= grp_emit[0];
            out_emit_b  <= grp_emit[1];
            out_id_a    <= eff_cfg.id_a;
            out_id_b    <= eff_cfg.id_b;
            out_cfg_err <= conflict;
            out_samples <= gated;
         end
      end
   end

   // R8
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
   // R6
   valid_has_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_emit_a || out_emit_b));
   // R4
   grp_a_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_emit_a |-> (out_samples[GRP_BITS-1:0] == '0));
   // R5
   grp_b_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_emit_b |-> (out_samples[2*GRP_BITS-1:GRP_BITS] == '0));
   // R9
   conflict_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_cfg_err |-> (!out_emit_b && out_emit_a && out_id_a == out_id_b));
endmodule

// File: tb/audio_act_gate_tb_top.sv
module audio_act_gate_tb_top;
   localparam int CLK_P = 10;
   localparam int SW    = 24;
   localparam int NCH   = 8;
   localparam int AW    = 4;
   localparam int DW    = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [DW-1:0]     wr_data = '0;
   logic              in_valid = 1'b0;
   logic              in_sop = 1'b0;
   logic [NCH*SW-1:0] in_samples = '0;
   logic              out_valid, out_emit_a, out_emit_b, out_cfg_err;
   logic [1:0]        out_id_a, out_id_b;
   logic [NCH*SW-1:0] out_samples;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [7:0] st_mask = 8'hFF, ac_mask = 8'hFF;
   logic [1:0] st_ida = 2'd0, st_idb = 2'd1, ac_ida = 2'd0, ac_idb = 2'd1;
   logic       e_valid, e_ea, e_eb, e_err;
   logic [NCH*SW-1:0] e_samp;

   always #(CLK_P/2) clk = ~clk;

   audio_act_gate #(.SAMPLE_W(SW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .in_valid(in_valid), .in_sop(in_sop),
      .in_samples(in_samples), .out_valid(out_valid), .out_emit_a(out_emit_a),
      .out_emit_b(out_emit_b), .out_id_a(out_id_a), .out_id_b(out_id_b),
      .out_cfg_err(out_cfg_err), .out_samples(out_samples)
   );

   function automatic logic [NCH*SW-1:0] exp_lanes(logic [7:0] m, logic ea, logic eb,
                                                   logic [NCH*SW-1:0] s);
      logic [NCH*SW-1:0] r = '0;
      for (int n = 0; n < NCH; n++) begin
         if (m[n] && ((n < 4) ? ea : eb)) r[n*SW +: SW] = s[n*SW +: SW];
      end
      return r;
   endfunction

   task automatic chk(string tag, logic [NCH*SW-1:0] act, logic [NCH*SW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 0) st_mask = d[7:0];
      if (a == 1) begin st_ida = d[1:0]; st_idb = d[3:2]; end
   endtask

   task automatic slot(logic sop, logic [NCH*SW-1:0] s, string tag);
      logic aa, ab;
      @(negedge clk);
      in_valid = 1'b1; in_sop = sop; in_samples = s;
      if (sop) begin ac_mask = st_mask; ac_ida = st_ida; ac_idb = st_idb; end
      aa    = |ac_mask[3:0];
      ab    = |ac_mask[7:4];
      e_err = aa && ab && (ac_ida == ac_idb);
      e_ea  = aa;
      e_eb  = ab && !e_err;
      e_valid = e_ea || e_eb;
      e_samp  = exp_lanes(ac_mask, e_ea, e_eb, s);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0;
      chk({tag, " valid R8"}, NCH*SW'(out_valid), NCH*SW'(e_valid));
      chk({tag, " emit_a R4"}, NCH*SW'(out_emit_a), NCH*SW'(e_ea));
      chk({tag, " emit_b R5"}, NCH*SW'(out_emit_b), NCH*SW'(e_eb));
      chk({tag, " ids R8"}, NCH*SW'({out_id_a, out_id_b}), NCH*SW'({ac_ida, ac_idb}));
      chk({tag, " cfg_err R9"}, NCH*SW'(out_cfg_err), NCH*SW'(e_err));
      chk({tag, " lanes R2 R3"}, out_samples, e_samp);
   endtask

   function automatic logic [NCH*SW-1:0] rnd_samples();
      logic [NCH*SW-1:0] r;
      for (int n = 0; n < NCH; n++) r[n*SW +: SW] = SW'($urandom());
      return r;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("reset valid R1", NCH*SW'(out_valid), '0);
      chk("reset ids R1", NCH*SW'({out_id_a, out_id_b}), NCH*SW'(4'b0001));
      slot(1'b1, rnd_samples(), "R1 default");
      // R8: strobe drops after idle
      @(negedge clk);
      chk("idle valid R8", NCH*SW'(out_valid), '0);
      // R3 partial mask
      wr(0, 32'h5A);
      slot(1'b1, rnd_samples(), "R3 partial");
      // R5 group B off
      wr(0, 32'h0F);
      slot(1'b1, rnd_samples(), "R5 b off");
      // R4 group A off
      wr(0, 32'hF0);
      slot(1'b1, rnd_samples(), "R4 a off");
      // R6 all off
      wr(0, 32'h00);
      slot(1'b1, rnd_samples(), "R6 all off");
      // R7: write without sop keeps old config
      wr(0, 32'h81);
      slot(1'b0, rnd_samples(), "R7 no sop");
      slot(1'b1, rnd_samples(), "R7 sop");
      // R9 id conflict
      wr(1, 32'h0A);
      slot(1'b1, rnd_samples(), "R9 conflict");
      // R10 unused address ignored, then ids distinct
      wr(5, 32'hFFFF_FF00);
      wr(1, 32'h0B);
      slot(1'b1, rnd_samples(), "R10 ignore");
      // random mix
      for (int i = 0; i < 400; i++) begin
         int k = $urandom_range(0, 9);
         if (k < 2) wr(0, DW'($urandom_range(0, 255)));
         else if (k == 2) wr(1, DW'($urandom_range(0, 15)));
         else if (k == 3) wr(AW'($urandom_range(2, 15)), $urandom());
         slot(1'($urandom_range(0, 1)), rnd_samples(), "rand R2 R7");
      end
      finish_run();
   end
endmodule